// File: doc/BRIEF.md
# Strided Subset-Skip Address Generator

This block generates the address stream for a small data memory. It walks the memory from a programmed starting point and moves by a signed stride on every enabled cycle. A down counter groups the addresses into subsets of programmable length. When a subset ends, the move also adds a signed skip, and the counter starts the next subset. These four settings give many scan shapes: plain forward and backward sweeps, every-other-word sweeps, column walks through a row-major matrix, small rectangular tiles inside wider rows, and rotated sweeps that begin one word further on each pass.

Software or a sequencer writes the four settings through a single write port. A start pulse then arms the scan. After that, the consumer raises the enable input once for each address it takes. The address and the valid flag come straight from registers.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addr_o` is 0 and `valid_o` is 0 until the first start.
- R2: A write with `cfg_we_i` high stores `cfg_data_i` into one setting, chosen by `cfg_sel_i`: 0 = base, 1 = step, 2 = subset length, 3 = skip. A write does not change a running scan. The new setting is used only from the next start.
- R3: A start pulse makes the next cycle show the base address on `addr_o` with `valid_o` high. Start takes priority over enable in the same cycle.
- R4: While `valid_o` is high and `en_i` is high, and the current address is not the last address of a subset, the next address is the current address plus step. Step is an 8-bit two's-complement value.
- R5: The current address is the last of a subset when subset-length addresses have been issued since the start or since the previous boundary. On an enabled cycle at that address, the next address is current + step + skip, and a new subset begins. Skip is two's complement. A length of 1 puts a boundary on every advance. A length of 0 means 256.
- R6: While `en_i` is low and no start occurs, `addr_o` and `valid_o` hold their values.
- R7: Before the first start, `en_i` has no effect.
- R8: Address arithmetic wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_sel_i | input | 2 | Setting select (0 base, 1 step, 2 subset, 3 skip) |
| cfg_data_i | input | 8 | Setting write value |
| start_i | input | 1 | Loads the base and begins a new first subset |
| en_i | input | 1 | Advance request |
| addr_o | output | 8 | Current address |
| valid_o | output | 1 | High once a scan has been started |

## Verification
The hardest case to reach is a subset boundary that coincides with something else: a setting write in the same cycle, a start that pre-empts the boundary advance, or a boundary on every cycle when the length is 1. Random stimulus uses short subset lengths, so boundaries come often. It mixes random enable gaps with random writes and starts in the middle of a scan. Directed tile, rotation, wrap and length-0 runs cover the exact address sequences.

// File: rtl/scan_ag_pkg.sv
package scan_ag_pkg;
  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_STEP   = 2'd1,
    SEL_SUBSET = 2'd2,
    SEL_SKIP   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] subset_o,
  output logic [AW-1:0] skip_o
);
  import scan_ag_pkg::*;

  logic [AW-1:0] field_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      field_q[g] <= '0;
      else if (we_i && sel_i == 2'(g)) field_q[g] <= data_i;
    end
  end

  assign base_o   = field_q[SEL_BASE];
  assign step_o   = field_q[SEL_STEP];
  assign subset_o = field_q[SEL_SUBSET];
  assign skip_o   = field_q[SEL_SKIP];

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_STEP) |=> step_o == $past(data_i));
endmodule

// File: rtl/scan_subset_ctr.sv
module scan_subset_ctr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] len_i,
  output logic          last_o
);
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] len_q;
  logic [AW-1:0] reload;

  // length 0 wraps to all-ones, giving 2^AW addresses per subset
  assign reload = len_q - AW'(1);
  assign last_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - AW'(1);
      len_q <= len_i;
    end else if (adv_i) begin
      cnt_q <= last_o ? reload : cnt_q - AW'(1);
    end
  end

  a_r5_load_len1_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i == AW'(1)) |=> last_o);
  a_r5_boundary_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && last_o && len_q != AW'(1)) |=> !last_o);
endmodule

// File: rtl/scan_addr_accum.sv
module scan_addr_accum #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          last_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] skip_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] step_q, skip_q, addr_q, addr_nxt;

  assign addr_nxt = addr_q + step_q + (last_i ? skip_q : '0);
  assign addr_o   = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      step_q <= '0;
      skip_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      step_q <= step_i;
      skip_q <= skip_i;
    end else if (adv_i) begin
      addr_q <= addr_nxt;
    end
  end

  a_r3_load_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(base_i));
  a_r4_plain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && !last_i) |=> addr_o == $past(addr_o + step_q));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(addr_o));
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  input  logic          start_i,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o
);
  logic [AW-1:0] base, step, subset, skip;
  logic          valid_q, adv, last;

  assign adv     = en_i && valid_q && !start_i;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (start_i) valid_q <= 1'b1;
  end

  scan_cfg_regs #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .base_o(base), .step_o(step), .subset_o(subset), .skip_o(skip)
  );

  scan_subset_ctr #(.AW(AW)) u_ctr (
    .clk_i, .rst_ni, .load_i(start_i), .adv_i(adv), .len_i(subset), .last_o(last)
  );

  scan_addr_accum #(.AW(AW)) u_acc (
    .clk_i, .rst_ni, .load_i(start_i), .adv_i(adv), .last_i(last),
    .base_i(base), .step_i(step), .skip_i(skip), .addr_o(addr_o)
  );

  a_r7_idle_until_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> (!valid_o && addr_o == '0));
  a_r3_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: tb/sim_scan_addr_gen.sv
module sim_scan_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_we = 1'b0, start = 1'b0, en = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic [7:0] addr;
  logic       valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] sh [4];
  logic [7:0] m_base, m_step, m_len, m_skip, m_addr, m_cnt;
  logic       m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .start_i(start), .en_i(en), .addr_o(addr), .valid_o(valid)
  );

  function automatic logic [7:0] plus(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    return a + b + c;
  endfunction

  task automatic check(string tag, logic [7:0] ea, logic ev);
    n_chk++;
    if (addr !== ea || valid !== ev) begin
      n_bad++;
      $display("FAIL %s: addr=%0d valid=%0b expected addr=%0d valid=%0b", tag, addr, valid, ea, ev);
    end
  endtask

  task automatic cyc(logic st, logic e, logic we, logic [1:0] sel, logic [7:0] d, string tag);
    string t;
    @(negedge clk);
    start = st; en = e; cfg_we = we; cfg_sel = sel; cfg_data = d;
    if (st) t = "R3";
    else if (e && m_valid && m_cnt == 0) t = "R5";
    else if (e && m_valid) t = "R4";
    else if (!m_valid) t = "R7";
    else t = "R6";
    if (tag != "") t = tag;
    if (st) begin
      m_base = sh[0]; m_step = sh[1]; m_len = sh[2]; m_skip = sh[3];
      m_addr = m_base; m_cnt = m_len - 8'd1; m_valid = 1'b1;
    end else if (e && m_valid) begin
      if (m_cnt == 0) begin
        m_addr = plus(m_addr, m_step, m_skip); m_cnt = m_len - 8'd1;
      end else begin
        m_addr = plus(m_addr, m_step, 8'd0); m_cnt = m_cnt - 8'd1;
      end
    end
    @(posedge clk); #1;
    if (we) sh[sel] = d;
    check(t, m_addr, m_valid);
  endtask

  task automatic setcfg(logic [7:0] b, logic [7:0] s, logic [7:0] l, logic [7:0] k);
    cyc(0, 0, 1, 2'd0, b, "R2");
    cyc(0, 0, 1, 2'd1, s, "R2");
    cyc(0, 0, 1, 2'd2, l, "R2");
    cyc(0, 0, 1, 2'd3, k, "R2");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 2'd0, 8'd0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] exp_seq [7];
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) sh[i] = '0;
    m_addr = '0; m_cnt = '0; m_valid = 0;
    m_base = '0; m_step = '0; m_len = '0; m_skip = '0;
    #(CLK_PERIOD * 2 + 3);
    check("R1", 8'd0, 1'b0);
    rst_n = 1'b1;
    // R7: enable before any start has no effect
    setcfg(8'd40, 8'd1, 8'd4, 8'd0);
    run(3);
    // R3 start beats enable; then R4/R5 tile scan, width 16
    setcfg(8'd0, 8'd1, 8'd3, 8'd13);
    cyc(1, 1, 0, 2'd0, 8'd0, "R3");
    exp_seq = '{8'd1, 8'd2, 8'd16, 8'd17, 8'd18, 8'd32, 8'd33};
    for (int i = 0; i < 7; i++) begin
      cyc(0, 1, 0, 2'd0, 8'd0, "");
      if (addr !== exp_seq[i]) begin
        n_bad++; $display("FAIL R5: tile addr=%0d expected=%0d", addr, exp_seq[i]);
      end
      n_chk++;
    end
    // R6 hold
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 2'd0, 8'd0, "R6");
    // R2 write mid-scan has no effect until next start
    cyc(0, 1, 1, 2'd1, 8'd5, "R2");
    run(3);
    // rotating reverse: step -1, len 8, skip +7
    setcfg(8'd7, 8'hFF, 8'd8, 8'd7);
    cyc(1, 0, 0, 2'd0, 8'd0, "R3");
    run(10);
    // R8 wrap
    setcfg(8'd250, 8'd3, 8'd0, 8'd0);
    cyc(1, 0, 0, 2'd0, 8'd0, "R3");
    cyc(0, 1, 0, 2'd0, 8'd0, "R8");
    cyc(0, 1, 0, 2'd0, 8'd0, "R8");
    if (addr !== 8'd0) begin n_bad++; $display("FAIL R8: addr=%0d expected=0", addr); end
    n_chk++;
    // R5 length 1: skip every advance
    setcfg(8'd10, 8'd2, 8'd1, 8'hFE);
    cyc(1, 0, 0, 2'd0, 8'd0, "R3");
    run(4);
    // random mix
    for (int r = 0; r < 60; r++) begin
      setcfg(8'($urandom), 8'($urandom), 8'($urandom_range(0, 9)), 8'($urandom));
      cyc(1, 1, 0, 2'd0, 8'd0, "R3");
      for (int i = 0; i < 40; i++) begin
        int p;
        p = $urandom_range(0, 99);
        cyc(p < 3, p < 70, p >= 90, 2'($urandom), 8'($urandom), "");
      end
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule